// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block collects the level-sensitive interrupt pins (INTA through INTD) of every device slot on one PCI bus and turns them into a 16-line input vector for a legacy interrupt controller. Routing happens in two stages. First, a fixed rotation based on the slot number folds each device pin onto one of four shared interrupt lines, A to D. Second, four byte-wide steering registers, one per shared line, choose which legacy IRQ that line drives.

The steering registers sit behind a small byte-wide register port. A byte whose top bit is set turns its line off. A byte whose low seven bits are 16 or more leaves its line unrouted. When several shared lines select the same IRQ, that output is their logical OR. The shared-line levels are registered once per clock. The 16 outputs are recomputed from those registered levels and the current register contents, so a register rewrite moves an active level to its new IRQ straight away.

At reset, a profile select input picks one of two sets of power-up steering values.

Top module: `pci_irq_router`

## Requirements
- R1: While `rst_n` is low at a clock edge with `rst_profile` = 0, all four steering registers load 0x80. After reset, `irq_o` stays all zero whatever the pins do.
- R2: While `rst_n` is low at a clock edge with `rst_profile` = 1, the steering registers load 0x0A, 0x0A, 0x0B, 0x0B for lines A, B, C, D (register addresses 0 to 3).
- R3: Slot s owns `dev_int[4s+3:4s]`, and bit p is its pin p (0 = INTA). That pin feeds shared line (p + s − 1) mod 4, where line 0 is A and line 3 is D.
- R4: A steering byte with bit 7 clear and a value below 16 routes its line to the IRQ of that number: `irq_o` bit n = value.
- R5: A steering byte with bit 7 set leaves its line unrouted, whatever its low bits hold.
- R6: A steering byte with bit 7 clear and a value from 16 to 127 leaves its line unrouted.
- R7: Each `irq_o` bit is the OR of every active shared line whose steering byte selects that IRQ.
- R8: A pin change sampled at a rising clock edge appears on `irq_o` right after that edge and not before it.
- R9: A steering register written at a rising edge moves an active line's level to its new IRQ right after that same edge.
- R10: Reading a steering register through `reg_addr` returns the last byte written to it unchanged, bit 7 included. The read is combinational.
- R11: A shared line is active while any pin folded onto it is high, and it goes inactive only when all of those pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_profile | input | 1 | Selects the power-up steering values applied during reset |
| dev_int | input | 4*NUM_SLOTS | Device interrupt pins, 4 per slot, active high |
| reg_we | input | 1 | Write strobe for the steering registers |
| reg_addr | input | 2 | Steering register select, 0..3 for lines A..D |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte of the selected register |
| irq_o | output | NUM_IRQS | Legacy IRQ levels to the interrupt controller |

## Verification
A wrong steering byte, a wrong bit-7 or range decode, or a wrong slot rotation shows on `irq_o` one clock after the pin pattern is applied. It appears as a level on the wrong IRQ, or as a missing level. A stale or corrupted register shows on `reg_rdata` during the very cycle it is addressed. A wrong merge shows only when two lines share a target, so the bench sweeps every combination of active lines under both shared and separate targets. It also sweeps each pin of every slot alone and every value of one steering byte.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned PINS_PER_SLOT = 4;
  localparam int unsigned LINES         = 4;
  localparam int unsigned REG_W         = 8;
  localparam int unsigned ADDR_W        = $clog2(LINES);

  typedef logic [REG_W-1:0] route_t;

  // power-up steering values, index = line
  localparam route_t PROF0_VAL [LINES] = '{8'h80, 8'h80, 8'h80, 8'h80};
  localparam route_t PROF1_VAL [LINES] = '{8'h0A, 8'h0A, 8'h0B, 8'h0B};

  // slot rotation: pin p of slot s lands on line (p + s - 1) mod LINES
  function automatic int unsigned fold_line(int unsigned slot, int unsigned pin);
    return (pin + slot + LINES - 1) % LINES;
  endfunction

  // a steering byte is a live route when its off flag is clear and the number fits
  function automatic logic route_ok(route_t v, int unsigned nirq);
    return !v[REG_W-1] && ({25'd0, v[REG_W-2:0]} < nirq);
  endfunction
endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0]  dev_int,
  output logic [LINES-1:0]                    pirq_q
);
  localparam int unsigned PIN_W = NUM_SLOTS * PINS_PER_SLOT;

  function automatic logic [PIN_W-1:0] line_mask(int unsigned l);
    logic [PIN_W-1:0] m;
    m = '0;
    for (int unsigned s = 0; s < NUM_SLOTS; s++)
      for (int unsigned p = 0; p < PINS_PER_SLOT; p++)
        if (fold_line(s, p) == l) m[s*PINS_PER_SLOT+p] = 1'b1;
    return m;
  endfunction

  logic [LINES-1:0] line_fold;

  for (genvar l = 0; l < LINES; l++) begin : g_fold
    assign line_fold[l] = |(dev_int & line_mask(l));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pirq_q <= '0;
    else        pirq_q <= line_fold;
  end

  AST_PIRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_int == '0) |=> (pirq_q == '0)); // R11
  AST_PIRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_int) |=> (|pirq_q)); // R8
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rst_profile,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [REG_W-1:0]           reg_wdata,
  output logic [REG_W-1:0]           reg_rdata,
  output logic [LINES-1:0][REG_W-1:0] route_q
);
  for (genvar l = 0; l < LINES; l++) begin : g_reg
    logic hit_wr;
    assign hit_wr = reg_we && (reg_addr == ADDR_W'(l));
    always_ff @(posedge clk) begin
      if (!rst_n)      route_q[l] <= rst_profile ? PROF1_VAL[l] : PROF0_VAL[l];
      else if (hit_wr) route_q[l] <= reg_wdata;
    end
  end

  assign reg_rdata = route_q[reg_addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (route_q[$past(reg_addr)] == $past(reg_wdata))); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(route_q)); // R10
endmodule

// File: rtl/pirq_irq_merge.sv
module pirq_irq_merge
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_IRQS = 16
) (
  input  logic [LINES-1:0]            pirq_q,
  input  logic [LINES-1:0][REG_W-1:0] route_q,
  output logic [LINES-1:0]            line_live,
  output logic [NUM_IRQS-1:0]         irq_o
);
  for (genvar l = 0; l < LINES; l++) begin : g_live
    assign line_live[l] = pirq_q[l] && route_ok(route_q[l], NUM_IRQS);
  end

  for (genvar i = 0; i < NUM_IRQS; i++) begin : g_irq
    logic [LINES-1:0] hit;
    for (genvar l = 0; l < LINES; l++) begin : g_hit
      assign hit[l] = line_live[l] && (route_q[l][REG_W-2:0] == (REG_W-1)'(i));
    end
    assign irq_o[i] = |hit;
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned NUM_IRQS  = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rst_profile,
  input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] dev_int,
  input  logic                               reg_we,
  input  logic [ADDR_W-1:0]                  reg_addr,
  input  logic [REG_W-1:0]                   reg_wdata,
  output logic [REG_W-1:0]                   reg_rdata,
  output logic [NUM_IRQS-1:0]                irq_o
);
  logic [LINES-1:0]            pirq_q;
  logic [LINES-1:0][REG_W-1:0] route_q;
  logic [LINES-1:0]            line_live;
  logic                        all_off;

  pirq_swizzle #(.NUM_SLOTS(NUM_SLOTS)) i_swizzle (
    .clk(clk), .rst_n(rst_n), .dev_int(dev_int), .pirq_q(pirq_q)
  );

  pirq_route_regs i_regs (
    .clk(clk), .rst_n(rst_n), .rst_profile(rst_profile),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .route_q(route_q)
  );

  pirq_irq_merge #(.NUM_IRQS(NUM_IRQS)) i_merge (
    .pirq_q(pirq_q), .route_q(route_q), .line_live(line_live), .irq_o(irq_o)
  );

  always_comb begin
    all_off = 1'b1;
    for (int l = 0; l < LINES; l++) all_off = all_off && route_q[l][REG_W-1];
  end

  AST_FANOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_o) <= $countones(pirq_q)); // R7
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    all_off |-> (irq_o == '0)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pirq_q == '0) |-> (irq_o == '0)); // R11
endmodule

// File: tb/test_pci_irq_router.sv
module test_pci_irq_router;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NP = NS * 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rst_profile = 1'b0;
  logic [NP-1:0]   dev_int = '0;
  logic            reg_we = 1'b0;
  logic [1:0]      reg_addr = '0;
  logic [7:0]      reg_wdata = '0;
  logic [7:0]      reg_rdata;
  logic [15:0]     irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] shadow [4];

  pci_irq_router #(.NUM_SLOTS(NS), .NUM_IRQS(16)) i_pci_irq_router (
    .clk(clk), .rst_n(rst_n), .rst_profile(rst_profile), .dev_int(dev_int),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(logic [NP-1:0] pins);
    logic [3:0]  lv = '0;
    logic [15:0] r  = '0;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < 4; p++)
        if (pins[s*4+p]) begin
          int k = (s - 1 + p + 4) % 4;
          lv[k] = 1'b1;
        end
    for (int l = 0; l < 4; l++)
      if (lv[l] && shadow[l] < 8'h10) r[shadow[l][3:0]] = 1'b1;
    return r;
  endfunction

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    shadow[a] = d;
  endtask

  task automatic pins(logic [NP-1:0] v);
    @(negedge clk);
    dev_int = v;
    @(negedge clk);
  endtask

  task automatic rd_chk(string req, int a);
    reg_addr = 2'(a);
    #1;
    chk(req, {24'd0, reg_rdata}, {24'd0, shadow[a]});
  endtask

  task automatic do_reset(logic prof);
    @(negedge clk);
    rst_n = 1'b0; rst_profile = prof; dev_int = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    if (prof) shadow = '{8'h0A, 8'h0A, 8'h0B, 8'h0B};
    else      shadow = '{8'h80, 8'h80, 8'h80, 8'h80};
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [NP-1:0] pv;
    // R1: profile 0
    do_reset(1'b0);
    chk("R1 out after reset", {16'd0, irq_o}, 32'd0);
    for (int a = 0; a < 4; a++) rd_chk("R1 reset value", a);
    pins('1);
    chk("R1 all pins high", {16'd0, irq_o}, 32'd0);

    // R2: profile 1
    do_reset(1'b1);
    for (int a = 0; a < 4; a++) rd_chk("R2 reset value", a);
    pins('1);
    chk("R2 all pins high", {16'd0, irq_o}, {16'd0, model('1)});
    chk("R2 lines to 10/11", {16'd0, irq_o}, 32'h0000_0C00);

    // R3: every pin alone, distinct targets
    pins('0);
    for (int a = 0; a < 4; a++) wr(a, 8'(4 + a));
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < 4; p++) begin
        pv = '0; pv[s*4+p] = 1'b1;
        pins(pv);
        chk("R3 slot rotation", {16'd0, irq_o}, {16'd0, model(pv)});
      end

    // R4 R5 R6 R10: full value sweep of line A
    for (int a = 1; a < 4; a++) wr(a, 8'h80);
    pv = '0; pv[4] = 1'b1;  // slot 1 pin 0 -> line A
    pins(pv);
    for (int v = 0; v < 256; v++) begin
      wr(0, 8'(v));
      rd_chk("R10 readback", 0);
      if (v < 16)       chk("R4 valid route", {16'd0, irq_o}, 32'd1 << v);
      else if (v > 127) chk("R5 off flag",    {16'd0, irq_o}, 32'd0);
      else              chk("R6 out of range", {16'd0, irq_o}, 32'd0);
    end

    // R7: every line combination, shared then paired targets
    for (int a = 0; a < 4; a++) wr(a, 8'd5);
    for (int m = 0; m < 16; m++) begin
      pv = '0;
      for (int l = 0; l < 4; l++) if (m[l]) pv[4+l] = 1'b1;  // slot 1 pin l -> line l
      pins(pv);
      chk("R7 shared target", {16'd0, irq_o}, {16'd0, model(pv)});
    end
    wr(0, 8'd3); wr(1, 8'd3); wr(2, 8'd12); wr(3, 8'd12);
    for (int m = 0; m < 16; m++) begin
      pv = '0;
      for (int l = 0; l < 4; l++) if (m[l]) pv[4+l] = 1'b1;
      pins(pv);
      chk("R7 paired targets", {16'd0, irq_o}, {16'd0, model(pv)});
    end

    // R11: three pins on line A
    wr(0, 8'd6); wr(1, 8'h80); wr(2, 8'h80); wr(3, 8'h80);
    pv = '0; pv[4] = 1'b1; pv[11] = 1'b1; pv[1] = 1'b1;
    pins(pv);
    chk("R11 three pins", {16'd0, irq_o}, 32'h0000_0040);
    pv[11] = 1'b0;
    pins(pv);
    chk("R11 two left", {16'd0, irq_o}, 32'h0000_0040);
    pv[4] = 1'b0;
    pins(pv);
    chk("R11 one left", {16'd0, irq_o}, 32'h0000_0040);
    pins('0);
    chk("R11 none left", {16'd0, irq_o}, 32'd0);

    // R8: latency of one edge
    wr(0, 8'd2);
    @(negedge clk);
    pv = '0; pv[4] = 1'b1;
    dev_int = pv;
    #1;
    chk("R8 before edge", {16'd0, irq_o}, 32'd0);
    @(negedge clk);
    chk("R8 after edge", {16'd0, irq_o}, 32'h0000_0004);

    // R9: rewrite moves an active level
    wr(0, 8'd9);
    chk("R9 moved level", {16'd0, irq_o}, 32'h0000_0200);
    wr(0, 8'h89);
    chk("R5 off flag on live line", {16'd0, irq_o}, 32'd0);
    rd_chk("R10 bit 7 kept", 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule